// File: doc/BRIEF.md
# Dual-Mode Configuration Port

This block is the control front end of a data converter. A strap input chooses how three shared input pins are read. With the strap low, the pins form a serial register port: a select line framing each transfer, a shift clock and a data line. Together with a serial data output, this port writes and reads a small bank of mode-control registers. With the strap high, the same pins are treated as static logic levels. The shift-clock pin then drives the sleep control directly, and the select pin drives the clock duty-cycle stabilizer enable directly.

All pins are oversampled in the system clock domain through synchronizers. A serial transfer is a 16-bit word, sent most significant bit first and sampled on rising shift-clock edges. Bit 15 selects the direction (0 = write, 1 = read), bits 14:8 carry the register address, and bits 7:0 carry the data. The block decodes the stored register fields into control outputs for downstream logic.

Register map: address 0 is a command register (bit 7 = soft reset, always reads 0). Address 1 is power control (bit 0 = sleep). Address 2 is clock control (bit 0 = stabilizer enable, bits 3:1 = output clock phase). Address 3 is output configuration (all 8 bits). Reset defaults are 0x00, 0x00, 0x01 and 0x24 for addresses 0 to 3.

Top module: `cfg_port`

## Requirements
- R1: After reset, sleep_o=0, dcs_en_o=1, clk_phase_o=0, out_cfg_o=0x24, sdo_o=0 and sdo_oe_o=0.
- R2: In serial mode, a 16-bit frame with bit 15 = 0 writes data bits 7:0 to the register at address bits 14:8 once the select line rises. The decoded outputs then follow the new value.
- R3: A frame is committed only if the select line rises after exactly 16 rising shift-clock edges. Frames of 15 or 17 edges leave every register unchanged.
- R4: A frame with bit 15 = 1 drives the addressed register on sdo_o, MSB first, during the final 8 clocks. Each bit changes after a falling shift-clock edge. sdo_oe_o is high only then; otherwise sdo_o and sdo_oe_o are low.
- R5: Shift-clock edges while the select line is high shift nothing and write nothing. A following 16-clock frame is still committed.
- R6: In parallel mode, sleep_o follows the shift-clock pin level and dcs_en_o follows the select pin level (high = enabled).
- R7: In parallel mode, the register bank is held at its defaults and serial activity on the pins writes nothing. Returning to serial mode leaves the defaults in place.
- R8: Writing address 0 with bit 7 set returns every register to its default. Writing address 0 with bit 7 clear changes nothing.
- R9: Writes to addresses 4 to 127 are ignored, and reads of address 0 or of addresses 4 to 127 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel_i | input | 1 | Strap: 0 = serial register port, 1 = parallel static controls |
| csn_i | input | 1 | Select line (serial) / stabilizer enable (parallel) |
| sclk_i | input | 1 | Shift clock (serial) / sleep control (parallel) |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out, low when not driven |
| sdo_oe_o | output | 1 | Output enable for sdo_o |
| sleep_o | output | 1 | Decoded sleep control |
| dcs_en_o | output | 1 | Decoded clock duty-cycle stabilizer enable |
| clk_phase_o | output | 3 | Output clock phase setting |
| out_cfg_o | output | 8 | Output driver configuration byte |

## Verification
The bench builds the block with its default parameters: 7 address bits, 8 data bits, two synchronizer stages and four registers. With four registers, addresses 5 and 127 are reachable as unmapped locations, and the 16-bit frame length makes the 15- and 17-clock boundary frames cheap to drive. With two synchronizer stages, the bench can run the shift clock at eight system clocks per half period and still leave margin for every edge detect and readback bit.

// File: rtl/cfg_port_pkg.sv
`timescale 1ns/1ps
package cfg_port_pkg;
   localparam int unsigned A_CMD = 0;
   localparam int unsigned A_PWR = 1;
   localparam int unsigned A_CLK = 2;
   localparam int unsigned A_OUT = 3;

   typedef struct packed {
      logic       sleep;
      logic       dcs_en;
      logic [2:0] clk_phase;
      logic [7:0] out_cfg;
   } cfg_fields_t;
endpackage

// File: rtl/cfg_pin_sync.sv
`timescale 1ns/1ps
module cfg_pin_sync #(
   parameter int unsigned       WIDTH   = 4,
   parameter int unsigned       STAGES  = 2,
   parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cfg_pin_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] pipe;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < int'(STAGES); s++) pipe[s] <= RST_VAL;
      end else begin
         pipe <= {pipe[STAGES-2:0], d_i};
      end
   end

   assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/cfg_spi_frame.sv
`timescale 1ns/1ps
module cfg_spi_frame #(
   parameter int unsigned ADDR_W = 7,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable_i,
   input  logic              csn_i,
   input  logic              sclk_i,
   input  logic              sdi_i,
   input  logic [DATA_W-1:0] rdata_i,
   output logic [ADDR_W-1:0] rd_addr_o,
   output logic              wr_stb_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic              sdo_o,
   output logic              sdo_oe_o
);
   localparam int unsigned FRAME = 1 + ADDR_W + DATA_W;
   localparam int unsigned HDR   = 1 + ADDR_W;
   localparam int unsigned CNT_W = $clog2(FRAME + 2);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   if (DATA_W < 2 || ADDR_W < 1) begin : g_bad_widths
      $error("cfg_spi_frame: field widths too small");
   end

   logic              sclk_q, csn_q;
   logic [FRAME-1:0]  shreg;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] shout;
   logic              oe;
   logic              rise, fall, csn_rise;

   assign rise     = sclk_i & ~sclk_q;
   assign fall     = ~sclk_i & sclk_q;
   assign csn_rise = csn_i & ~csn_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sclk_q    <= 1'b0;
         csn_q     <= 1'b1;
         shreg     <= '0;
         cnt       <= '0;
         shout     <= '0;
         oe        <= 1'b0;
         wr_stb_o  <= 1'b0;
         wr_addr_o <= '0;
         wr_data_o <= '0;
      end else begin
         sclk_q   <= sclk_i;
         csn_q    <= csn_i;
         wr_stb_o <= 1'b0;
         if (!enable_i) begin
            cnt <= '0;
            oe  <= 1'b0;
         end else if (csn_rise) begin
            if (cnt == CNT_W'(FRAME) && !shreg[FRAME-1]) begin
               wr_stb_o  <= 1'b1;
               wr_addr_o <= shreg[DATA_W +: ADDR_W];
               wr_data_o <= shreg[DATA_W-1:0];
            end
            cnt <= '0;
            oe  <= 1'b0;
         end else if (csn_i) begin
            cnt <= '0;
            oe  <= 1'b0;
         end else begin
            if (rise) begin
               shreg <= {shreg[FRAME-2:0], sdi_i};
               if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
            end
            if (fall) begin
               if (cnt == CNT_W'(HDR) && shreg[ADDR_W]) begin
                  shout <= rdata_i;
                  oe    <= 1'b1;
               end else if (oe) begin
                  shout <= {shout[DATA_W-2:0], 1'b0};
               end
            end
         end
      end
   end

   assign rd_addr_o = shreg[ADDR_W-1:0];
   assign sdo_o     = oe & shout[DATA_W-1];
   assign sdo_oe_o  = oe;

   // R5: no count accumulates while the select line is idle
   p_idle_cnt_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (csn_i && csn_q) |-> cnt == '0);
   // R4: read data is only driven inside a selected frame
   p_oe_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sdo_oe_o |-> !$past(csn_i));
   // R2: a commit is a single-cycle strobe
   p_stb_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb_o |=> !wr_stb_o);
   // R3: commits only follow an exact-length frame
   p_stb_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb_o |-> $past(cnt) == CNT_W'(FRAME));
endmodule

// File: rtl/cfg_reg_bank.sv
`timescale 1ns/1ps
module cfg_reg_bank
   import cfg_port_pkg::*;
#(
   parameter int unsigned NUM_REGS = 4,
   parameter int unsigned ADDR_W   = 7,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned SRST_BIT = 7,
   parameter logic [NUM_REGS*DATA_W-1:0] DEFAULTS = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold_i,
   input  logic              wr_stb_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [DATA_W-1:0] rdata_o,
   output cfg_fields_t       fields_o
);
   if (NUM_REGS < 4 || NUM_REGS > (1 << ADDR_W)) begin : g_bad_regs
      $error("cfg_reg_bank: NUM_REGS out of range");
   end
   if (DATA_W < 8 || SRST_BIT >= DATA_W) begin : g_bad_data
      $error("cfg_reg_bank: DATA_W or SRST_BIT out of range");
   end

   logic [DATA_W-1:0]          regs [NUM_REGS];
   logic [NUM_REGS*DATA_W-1:0] flat;
   logic                       srst;

   assign srst = wr_stb_i && (wr_addr_i == '0) && wr_data_i[SRST_BIT];

   always_ff @(posedge clk) begin
      for (int i = 0; i < int'(NUM_REGS); i++) begin
         if (!rst_n || hold_i || srst || i == 0) begin
            regs[i] <= DEFAULTS[i*DATA_W +: DATA_W];
         end else if (wr_stb_i && wr_addr_i == ADDR_W'(i)) begin
            regs[i] <= wr_data_i;
         end
      end
   end

   always_comb begin
      rdata_o = '0;
      for (int i = 1; i < int'(NUM_REGS); i++) begin
         if (rd_addr_i == ADDR_W'(i)) rdata_o = regs[i];
      end
   end

   always_comb begin
      for (int i = 0; i < int'(NUM_REGS); i++) flat[i*DATA_W +: DATA_W] = regs[i];
   end

   assign fields_o.sleep     = regs[A_PWR][0];
   assign fields_o.dcs_en    = regs[A_CLK][0];
   assign fields_o.clk_phase = regs[A_CLK][3:1];
   assign fields_o.out_cfg   = regs[A_OUT][7:0];

   // R7: holding forces the whole bank to defaults
   p_hold_def_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hold_i |=> flat == DEFAULTS);
   // R8: soft reset restores the whole bank
   p_soft_rst_r8: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> flat == DEFAULTS);
endmodule

// File: rtl/cfg_port.sv
`timescale 1ns/1ps
module cfg_port
   import cfg_port_pkg::*;
#(
   parameter int unsigned NUM_REGS    = 4,
   parameter int unsigned ADDR_W      = 7,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [NUM_REGS*DATA_W-1:0] DEFAULTS = 32'h2401_0000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mode_sel_i,
   input  logic       csn_i,
   input  logic       sclk_i,
   input  logic       sdi_i,
   output logic       sdo_o,
   output logic       sdo_oe_o,
   output logic       sleep_o,
   output logic       dcs_en_o,
   output logic [2:0] clk_phase_o,
   output logic [7:0] out_cfg_o
);
   localparam int unsigned NPINS = 4;

   logic [NPINS-1:0]  pins_s;
   logic              par_s, csn_s, sclk_s, sdi_s;
   logic [ADDR_W-1:0] rd_addr, wr_addr;
   logic [DATA_W-1:0] rdata, wr_data;
   logic              wr_stb;
   cfg_fields_t       fields;

   cfg_pin_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES), .RST_VAL(4'b0100)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d_i({mode_sel_i, csn_i, sclk_i, sdi_i}),
      .q_o(pins_s)
   );
   assign {par_s, csn_s, sclk_s, sdi_s} = pins_s;

   cfg_spi_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .enable_i(!par_s),
      .csn_i(csn_s), .sclk_i(sclk_s), .sdi_i(sdi_s),
      .rdata_i(rdata), .rd_addr_o(rd_addr),
      .wr_stb_o(wr_stb), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
      .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o)
   );

   cfg_reg_bank #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                  .SRST_BIT(7), .DEFAULTS(DEFAULTS)) u_bank (
      .clk(clk), .rst_n(rst_n), .hold_i(par_s),
      .wr_stb_i(wr_stb), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .rd_addr_i(rd_addr), .rdata_o(rdata), .fields_o(fields)
   );

   assign sleep_o     = par_s ? sclk_s : fields.sleep;
   assign dcs_en_o    = par_s ? csn_s  : fields.dcs_en;
   assign clk_phase_o = fields.clk_phase;
   assign out_cfg_o   = fields.out_cfg;

   // R7: no register write can be issued once parallel mode has settled
   p_no_write_par_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (par_s && $past(par_s)) |-> !wr_stb);
endmodule

// File: tb/cfg_port_test.sv
`timescale 1ns/1ps
module cfg_port_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_sel = 1'b0, csn = 1'b1, sclk = 1'b0, sdi = 1'b0;
   logic       sdo, sdo_oe, sleep, dcs_en;
   logic [2:0] clk_phase;
   logic [7:0] out_cfg;
   int         checks = 0, errors = 0;
   logic       oe_seen_hi, oe_seen_lo;

   always #4 clk = ~clk;

   cfg_port uut (
      .clk(clk), .rst_n(rst_n), .mode_sel_i(mode_sel), .csn_i(csn),
      .sclk_i(sclk), .sdi_i(sdi), .sdo_o(sdo), .sdo_oe_o(sdo_oe),
      .sleep_o(sleep), .dcs_en_o(dcs_en), .clk_phase_o(clk_phase), .out_cfg_o(out_cfg)
   );

   // {address, write data, expected readback}
   localparam logic [23:0] VEC [6] = '{
      {8'h01, 8'h01, 8'h01},
      {8'h02, 8'h0B, 8'h0B},
      {8'h03, 8'hC3, 8'hC3},
      {8'h05, 8'h77, 8'h00},
      {8'h7F, 8'h12, 8'h00},
      {8'h01, 8'hFE, 8'hFE}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic xfer(input logic [15:0] word, input int nbits, output logic [7:0] rd);
      rd = '0;
      oe_seen_hi = 1'b1;
      oe_seen_lo = 1'b0;
      csn = 1'b0;
      wait_clk(8);
      for (int i = 0; i < nbits; i++) begin
         sdi = (i < 16) ? word[15-i] : 1'b0;
         wait_clk(8);
         if (i >= 8 && i < 16) begin
            rd[15-i] = sdo;
            oe_seen_hi &= sdo_oe;
         end else begin
            oe_seen_lo |= sdo_oe;
         end
         sclk = 1'b1;
         wait_clk(8);
         sclk = 1'b0;
      end
      wait_clk(8);
      csn = 1'b1;
      wait_clk(12);
   endtask

   task automatic wr(input logic [6:0] a, input logic [7:0] d);
      logic [7:0] dummy;
      xfer({1'b0, a, d}, 16, dummy);
   endtask

   task automatic rd_reg(input logic [6:0] a, output logic [7:0] d);
      xfer({1'b1, a, 8'h00}, 16, d);
   endtask

   initial begin
      #(200000 * 8);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] r;
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);
      // R1 reset state
      check("R1 sleep", sleep, 0);
      check("R1 dcs", dcs_en, 1);
      check("R1 phase", clk_phase, 0);
      check("R1 out_cfg", out_cfg, 8'h24);
      check("R1 sdo", {sdo_oe, sdo}, 0);

      // R2 R4 R9: table walk of writes and readbacks
      for (int k = 0; k < 6; k++) begin
         wr(VEC[k][22:16], VEC[k][15:8]);
         rd_reg(VEC[k][22:16], r);
         check("R2/R9 readback", r, VEC[k][7:0]);
         check("R4 oe during read bits", oe_seen_hi, 1);
         check("R4 oe low in header", oe_seen_lo, 0);
         check("R4 idle sdo", {sdo_oe, sdo}, 0);
      end
      // R2 decoded fields: reg1=FE, reg2=0B, reg3=C3
      check("R2 sleep", sleep, 0);
      check("R2 dcs", dcs_en, 1);
      check("R2 phase", clk_phase, 3'd5);
      check("R2 out_cfg", out_cfg, 8'hC3);
      wr(7'h01, 8'h01);
      check("R2 sleep set", sleep, 1);
      wr(7'h02, 8'h00);
      check("R2 dcs cleared", dcs_en, 0);
      xfer({1'b0, 7'h02, 8'h00}, 16, r);
      check("R4 no oe on write", oe_seen_lo, 0);

      // R3 short and long frames
      xfer({1'b0, 7'h03, 8'h55}, 15, r);
      check("R3 15 clocks", out_cfg, 8'hC3);
      xfer({1'b0, 7'h03, 8'h55}, 17, r);
      check("R3 17 clocks", out_cfg, 8'hC3);

      // R5 clocks while deselected
      for (int i = 0; i < 16; i++) begin
         sdi = i[0];
         wait_clk(8);
         sclk = 1'b1;
         wait_clk(8);
         sclk = 1'b0;
      end
      wait_clk(12);
      check("R5 no write while deselected", out_cfg, 8'hC3);
      wr(7'h03, 8'h99);
      check("R5 next frame commits", out_cfg, 8'h99);

      // R8 / R9 command register
      wr(7'h00, 8'h7F);
      check("R8 bit7 clear no reset", out_cfg, 8'h99);
      rd_reg(7'h00, r);
      check("R9 addr0 reads zero", r, 0);
      wr(7'h00, 8'h80);
      check("R8 out_cfg default", out_cfg, 8'h24);
      check("R8 sleep default", sleep, 0);
      check("R8 dcs default", dcs_en, 1);
      rd_reg(7'h02, r);
      check("R8 reg2 default", r, 8'h01);

      // R6 / R7 parallel mode
      wr(7'h03, 8'h5A);
      check("R7 setup", out_cfg, 8'h5A);
      mode_sel = 1'b1;
      wait_clk(6);
      check("R7 held default", out_cfg, 8'h24);
      check("R6 sleep low", sleep, 0);
      check("R6 dcs high", dcs_en, 1);
      sclk = 1'b1;
      wait_clk(6);
      check("R6 sleep follows pin", sleep, 1);
      csn = 1'b0;
      wait_clk(6);
      check("R6 dcs follows pin", dcs_en, 0);
      sclk = 1'b0;
      csn = 1'b1;
      wait_clk(6);
      xfer({1'b0, 7'h03, 8'h66}, 16, r);
      check("R7 serial ignored", out_cfg, 8'h24);
      mode_sel = 1'b0;
      wait_clk(6);
      check("R7 after return", out_cfg, 8'h24);
      check("R7 sleep from reg", sleep, 0);
      rd_reg(7'h03, r);
      check("R7 readback default", r, 8'h24);

      // R1 reset again after activity
      wr(7'h03, 8'h11);
      rst_n = 1'b0;
      wait_clk(3);
      rst_n = 1'b1;
      wait_clk(4);
      check("R1 reset restores", out_cfg, 8'h24);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule